// File: doc/BRIEF.md
# Count-Headed Shifting Word Queue

This block is a first-in first-out queue of data words built as a row of parallel registers. The first position of the row is not data. It holds the number of words currently stored. The data positions follow it, so the oldest word always sits in position 1 and the newest sits at the position equal to the count. A store places the incoming word just past the current count and raises the count. A fetch hands out position 1, slides every later word one place toward the head in a single clock, and lowers the count.

Store and fetch are requested on two strobe inputs. In the default mode each strobe acts once on its rising edge. A level mode is also available, in which the strobe acts on every cycle it is high. The count, an empty flag and a carry flag are visible at all times. The carry flag reports that a store was turned away because every data position was taken. The total length `N` counts the count position and may be anything from 2 to 2048.

Top module: `ptr_shift_fifo`

## Requirements
- R1: While reset is held and after it is released, count is 0, empty is 1, carry is 0 and rd_data is 0.
- R2: An accepted store writes wr_data into position count+1 and raises count by 1 at the same clock edge. The first store after reset lands in position 1 and leaves count at 1.
- R3: A store that arrives while count equals N-1 is refused. The stored words and count stay as they were, and carry becomes 1. The next accepted store clears carry to 0. Count never exceeds N-1.
- R4: A fetch while count is non-zero loads rd_data with position 1 at the same clock edge, moves every word one position toward position 1, and lowers count by 1. Words therefore come out in the order they were stored.
- R5: A fetch while count is 0 changes nothing. Count stays 0, rd_data keeps its value and empty stays 1.
- R6: empty is 1 exactly when count is 0.
- R7: With EDGE_MODE=1, a strobe held high for several cycles causes exactly one operation, on the first clock edge at which it is seen high.
- R8: A store and a fetch in the same cycle act as fetch first, then store. When the queue is full, both are carried out, count stays N-1 and carry stays 0. When the queue is empty, the fetch does nothing and the word lands in position 1.
- R9: A fetch that is not paired with a store leaves the last position (N-1) unchanged rather than clearing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. It is asserted at once and released through a two-stage synchronizer. |
| wr_req | input | 1 | Store strobe |
| wr_data | input | DATA_W | Word to store |
| rd_req | input | 1 | Fetch strobe |
| rd_data | output | DATA_W | Last fetched word, registered |
| count | output | $clog2(N) | Number of stored words. This is the contents of position 0. |
| empty | output | 1 | High when count is 0 |
| carry | output | 1 | High after a refused store, until the next accepted store |

## Verification
A store and a fetch can meet in the same cycle. The bench provokes this by raising both strobes together in three states: an empty queue, a partly filled queue, and a full queue. A behavioural queue model applies fetch-then-store. Every cycle, it is compared with count, empty, carry and rd_data. Later fetches then show whether the paired word landed in the position just behind the surviving words.

// File: rtl/shift_fifo_pkg.sv
package shift_fifo_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_FETCH = 2'b01,
    OP_STORE = 2'b10,
    OP_BOTH  = 2'b11
  } sfifo_op_e;

endpackage

// File: rtl/sfifo_cmd_edge.sv
module sfifo_cmd_edge #(
  parameter bit EDGE_MODE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic go_o
);

  generate
    if (EDGE_MODE) begin : g_edge
      logic seen_q;
      logic seen_d;

      always_comb begin
        seen_d = req_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= seen_d;
      end

      assign go_o = req_i & ~seen_q;
    end else begin : g_level
      assign go_o = req_i;
    end
  endgenerate

endmodule

// File: rtl/sfifo_slots.sv
module sfifo_slots #(
  parameter int N      = 16,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] head_o,
  output logic [DATA_W-1:0] tail_o
);

  // position 0 is the count and lives in the controller
  logic [DATA_W-1:0] slot_w [N];

  assign slot_w[0] = '0;

  generate
    for (genvar i = 1; i < N; i++) begin : g_slot
      logic [DATA_W-1:0] q;
      logic [DATA_W-1:0] d;
      logic              hit;
      logic              ld;

      assign hit = wr_en && (wr_idx == IDX_W'(i));
      assign ld  = shift_en | hit;

      if (i < N - 1) begin : g_mid
        always_comb begin
          d = q;
          if (shift_en) d = slot_w[i+1];
          if (hit)      d = wr_data;
        end
      end else begin : g_last
        always_comb begin
          d = q;
          if (hit) d = wr_data;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d;
      end

      assign slot_w[i] = q;
    end
  endgenerate

  assign head_o = slot_w[1];
  assign tail_o = slot_w[N-1];

endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import shift_fifo_pkg::*;
#(
  parameter int N      = 16,
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic              rd_go,
  input  logic [DATA_W-1:0] head_i,
  output logic              shift_en,
  output logic              wr_en,
  output logic [CNT_W-1:0]  wr_idx,
  output logic [CNT_W-1:0]  count_o,
  output logic              carry_o,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(N - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              carry_q, carry_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              rd_ok, wr_ok, refuse, full;
  sfifo_op_e         op;

  always_comb begin
    full   = (cnt_q == CNT_FULL);
    rd_ok  = rd_go && (cnt_q != '0);
    wr_ok  = wr_go && (!full || rd_ok);
    refuse = wr_go && !wr_ok;
    op     = sfifo_op_e'({wr_ok, rd_ok});

    cnt_d   = cnt_q;
    rd_d    = rd_q;
    carry_d = carry_q;
    wr_idx  = cnt_q + 1'b1;

    unique case (op)
      OP_FETCH: begin
        cnt_d = cnt_q - 1'b1;
        rd_d  = head_i;
      end
      OP_STORE: begin
        cnt_d   = cnt_q + 1'b1;
        carry_d = 1'b0;
      end
      OP_BOTH: begin
        rd_d    = head_i;
        wr_idx  = cnt_q;
        carry_d = 1'b0;
      end
      default: ;
    endcase

    if (refuse) carry_d = 1'b1;

    shift_en = rd_ok;
    wr_en    = wr_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      carry_q <= 1'b0;
      rd_q    <= '0;
    end else begin
      if (rd_ok | wr_ok)  cnt_q   <= cnt_d;
      if (wr_go)          carry_q <= carry_d;
      if (rd_ok)          rd_q    <= rd_d;
    end
  end

  assign count_o   = cnt_q;
  assign carry_o   = carry_q;
  assign rd_data_o = rd_q;

endmodule

// File: rtl/ptr_shift_fifo.sv
module ptr_shift_fifo #(
  parameter int N         = 16,
  parameter int DATA_W    = 16,
  parameter bit EDGE_MODE = 1'b1,
  localparam int CNT_W    = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic              carry
);

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              wr_pulse, rd_pulse;
  logic              shift_en, wr_en;
  logic [CNT_W-1:0]  wr_idx;
  logic [DATA_W-1:0] head_word, tail_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  sfifo_cmd_edge #(.EDGE_MODE(EDGE_MODE)) u_wr_edge (
    .clk(clk), .rst_n(rst_sync_n), .req_i(wr_req), .go_o(wr_pulse)
  );

  sfifo_cmd_edge #(.EDGE_MODE(EDGE_MODE)) u_rd_edge (
    .clk(clk), .rst_n(rst_sync_n), .req_i(rd_req), .go_o(rd_pulse)
  );

  sfifo_ctrl #(.N(N), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_go(wr_pulse), .rd_go(rd_pulse), .head_i(head_word),
    .shift_en(shift_en), .wr_en(wr_en), .wr_idx(wr_idx),
    .count_o(count), .carry_o(carry), .rd_data_o(rd_data)
  );

  sfifo_slots #(.N(N), .DATA_W(DATA_W)) u_slots (
    .clk(clk), .rst_n(rst_sync_n),
    .shift_en(shift_en), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .head_o(head_word), .tail_o(tail_slot)
  );

  assign empty = (count == '0);

endmodule

// File: rtl/ptr_shift_fifo_chk.sv
module ptr_shift_fifo_chk #(
  parameter int N         = 16,
  parameter int DATA_W    = 16,
  parameter bit EDGE_MODE = 1'b1,
  localparam int CNT_W    = $clog2(N)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_pulse,
  input logic              rd_pulse,
  input logic [CNT_W-1:0]  count,
  input logic              empty,
  input logic              carry,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] tail
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(N - 1);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);

  a_r3_carry_on_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && !rd_pulse && count == FULL) |=> (carry && count == FULL));

  a_r2_store_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && !rd_pulse && count != FULL) |=>
      (count == CNT_W'($past(count) + 1'b1) && !carry));

  a_r4_fetch_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && !wr_pulse && count != '0) |=>
      (count == CNT_W'($past(count) - 1'b1)));

  a_r5_empty_fetch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && !wr_pulse && empty) |=> (empty && $stable(rd_data)));

  a_r8_pair_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && wr_pulse && count != '0) |=> ($stable(count) && !carry));

  a_r9_tail_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && !wr_pulse) |=> $stable(tail));

  generate
    if (EDGE_MODE) begin : g_edge_chk
      a_r7_single_wr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);
      a_r7_single_rd: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pulse |=> !rd_pulse);
    end
  endgenerate

endmodule

bind ptr_shift_fifo ptr_shift_fifo_chk #(
  .N(N), .DATA_W(DATA_W), .EDGE_MODE(EDGE_MODE)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .wr_pulse(wr_pulse), .rd_pulse(rd_pulse),
  .count(count), .empty(empty), .carry(carry),
  .rd_data(rd_data), .tail(tail_slot)
);

// File: tb/ptr_shift_fifo_bench.sv
`timescale 1ns/1ps
module ptr_shift_fifo_bench;

  localparam int N     = 16;
  localparam int W     = 16;
  localparam int CNT_W = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_req, rd_req;
  logic [W-1:0]  wr_data;
  logic [W-1:0]  rd_data;
  logic [CNT_W-1:0] count;
  logic          empty, carry;

  always #4 clk = ~clk;

  ptr_shift_fifo #(.N(N), .DATA_W(W), .EDGE_MODE(1'b1)) u_ptr_shift_fifo (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data),
    .rd_req(rd_req), .rd_data(rd_data), .count(count),
    .empty(empty), .carry(carry)
  );

  // behavioural reference
  logic [W-1:0] mq[$];
  logic [W-1:0] m_rd;
  logic         m_carry, m_pw, m_pr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      m_rd = '0; m_carry = 1'b0; m_pw = 1'b0; m_pr = 1'b0;
    end else begin
      logic wp, rp;
      wp = wr_req && !m_pw;
      rp = rd_req && !m_pr;
      m_pw = wr_req;
      m_pr = rd_req;
      if (rp && mq.size() > 0) m_rd = mq.pop_front();
      if (wp) begin
        if (mq.size() < N - 1) begin
          mq.push_back(wr_data);
          m_carry = 1'b0;
        end else begin
          m_carry = 1'b1;
        end
      end
    end
  end

  int    n_chk = 0;
  int    n_bad = 0;
  string tag   = "R1";
  bit    cmp_on = 1'b0;

  task automatic chk(input string t, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk({tag, " count"}, count, mq.size());
      chk("R6 empty", empty, mq.size() == 0);
      chk({tag, " carry"}, carry, m_carry);
      chk({tag, " rd_data"}, rd_data, m_rd);
    end
  end

  task automatic op(input bit w, input bit r, input logic [W-1:0] d);
    @(negedge clk);
    wr_req = w; rd_req = r; wr_data = d;
    @(negedge clk);
    wr_req = 1'b0; rd_req = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; wr_req = 1'b0; rd_req = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset count", count, 0);
    chk("R1 reset empty", empty, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 empty", empty, 1);
    chk("R1 carry", carry, 0);
    chk("R1 rd_data", rd_data, 0);
    cmp_on = 1'b1;

    tag = "R2";
    op(1, 0, 16'hA001);
    @(negedge clk); chk("R2 first store count", count, 1);
    op(1, 0, 16'hA002);
    op(1, 0, 16'hA003);

    tag = "R4";
    op(0, 1, '0);
    @(negedge clk); chk("R4 oldest first", rd_data, 16'hA001);
    op(0, 1, '0);
    op(0, 1, '0);
    @(negedge clk); chk("R4 third word", rd_data, 16'hA003);

    tag = "R5";
    op(0, 1, '0);
    @(negedge clk);
    chk("R5 empty fetch count", count, 0);
    chk("R5 rd_data held", rd_data, 16'hA003);

    tag = "R7";
    @(negedge clk); wr_req = 1'b1; wr_data = 16'hB0B0;
    repeat (4) @(negedge clk);
    chk("R7 held strobe single store", count, 1);
    wr_req = 1'b0;
    @(negedge clk); rd_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 held fetch single", count, 0);
    rd_req = 1'b0;

    tag = "R8";
    op(1, 1, 16'hC001);
    @(negedge clk); chk("R8 pair on empty", count, 1);
    op(1, 0, 16'hC002);
    op(1, 1, 16'hC003);
    @(negedge clk);
    chk("R8 pair mid fetch", rd_data, 16'hC001);
    chk("R8 pair mid count", count, 2);
    op(0, 1, '0);
    op(0, 1, '0);
    @(negedge clk); chk("R8 pair landed behind", rd_data, 16'hC003);

    tag = "R3";
    for (int i = 0; i < N - 1; i++) op(1, 0, W'(16'hD000 + i));
    @(negedge clk); chk("R3 full count", count, N - 1);
    op(1, 0, 16'hEEEE);
    @(negedge clk);
    chk("R3 refused carry", carry, 1);
    chk("R3 refused count", count, N - 1);

    tag = "R8";
    op(1, 1, 16'hF00F);
    @(negedge clk);
    chk("R8 pair at full count", count, N - 1);
    chk("R8 pair at full carry", carry, 0);
    chk("R8 pair at full head", rd_data, 16'hD000);

    tag = "R9";
    for (int i = 0; i < N - 1; i++) op(0, 1, '0);
    @(negedge clk);
    chk("R9 drained", count, 0);
    chk("R9 last word", rd_data, 16'hF00F);

    tag = "R3";
    op(1, 0, 16'h1234);
    op(0, 1, '0);
    @(negedge clk);
    chk("R3 store after drain", rd_data, 16'h1234);

    repeat (2) @(negedge clk);
    cmp_on = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule